// File: doc/BRIEF.md
# SMBus Control-Register Slave

This block is a slave on a two-wire SMBus-style bus. It holds a small bank of 8-bit control registers, such as per-output clock enables. Other logic on the chip reads these registers in parallel. A system controller reads and writes them over the bus. The block watches SCL and SDA through synchronizers clocked by the system clock. It detects START and STOP itself and pulls SDA low through an open-drain enable.

Every transfer begins with the slave address, followed by a command byte. Command bit 7 selects the access type: 1 means a single indexed byte, 0 means a block. For a single-byte access, bits 6:0 give the register offset. A block access always starts at register 0 and proceeds upward, and the controller may stop it after any whole byte. In a block write, the first data byte is a count, which the slave discards. In a block read, the first byte returned is the number of implemented registers. For reads, the controller sends a repeated START followed by the address with the read bit set.

Top module: `smb_ctl_slave`

## Requirements
- R1: After reset, every register holds RST_VAL, and the SDA pull-down enable `sda_oe_o` is low.
- R2: The slave ACKs an address byte only when bits 7:1 equal ADDR7; bit 0 = 1 means read. After any other address, it stays silent until the next START, and no register changes.
- R3: Byte write: a command with bit 7 = 1 and offset in bits 6:0, followed by one data byte, loads that byte into the register at the offset.
- R4: Byte read: the command, then a repeated START, then the read address. The slave returns the register at the offset, MSB first.
- R5: Block write: a command of 0x00, a count byte that is discarded, then data bytes. The data bytes go into register 0, 1, 2 and so on. A STOP after any whole byte leaves the higher registers unchanged.
- R6: Block read: the first byte returned is N_REGS, followed by register 0 upward. After a master NACK, the slave releases SDA.
- R7: A write to an offset at or above N_REGS is ACKed and changes nothing. A read from such an offset, including a block read past the last register, returns 0x00.
- R8: In byte mode, data bytes after the first are ACKed and discarded.
- R9: START and STOP are SDA edges while SCL is high. A repeated START restarts address decoding.
- R10: The slave pulls SDA low during the ACK bit of every address, command and data byte it accepts. It never pulls SDA low while the master drives data bits, and it changes SDA only while SCL is low, or at START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line, sensed value |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| regs_o | output | N_REGS*8 | Register bank, register k in bits 8k+7:8k |

## Verification
The bench builds the slave with N_REGS = 6 and RST_VAL = 0x5A. Because 6 is not a power of two, the index guard is exercised. Offsets 6 to 127 become reachable for the discard and zero-read cases, and a block read can step past the last register within a few bytes. The bench models the bus line and the register bank behaviourally. It compares the whole bank on every clock against the model.

// File: rtl/smb_slave_pkg.sv
package smb_slave_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_TX} st_e;
  typedef enum logic [1:0] {K_ADDR, K_CMD, K_CNT, K_DATA} kind_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_d  <= scl_ff[1];
      sda_d  <= sda_ff[1];
    end
  end

  assign scl_o      = scl_ff[1];
  assign sda_o      = sda_ff[1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // bus conditions only while SCL has been high for two samples
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;

  // R9
  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_rise_o |=> !scl_rise_o && !start_o && !stop_o);
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int          N_REGS  = 8,
  parameter int          AW      = 3,
  parameter logic [7:0]  RST_VAL = 8'hFF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [AW-1:0]         waddr_i,
  input  logic [7:0]            wdata_i,
  output logic [N_REGS-1:0][7:0] regs_o
);
  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         regs_o[g] <= RST_VAL;
      else if (we_i && waddr_i == AW'(g))  regs_o[g] <= wdata_i;
    end
  end

  // R7, R8
  hold_no_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_o));
endmodule

// File: rtl/smb_ctl_slave.sv
module smb_ctl_slave
  import smb_slave_pkg::*;
#(
  parameter logic [6:0] ADDR7   = 7'h69,
  parameter int         N_REGS  = 8,
  parameter logic [7:0] RST_VAL = 8'hFF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  output logic [N_REGS*8-1:0] regs_o
);
  localparam int         AW    = (N_REGS > 1) ? $clog2(N_REGS) : 1;
  localparam logic [7:0] NREG8 = 8'(N_REGS);
  localparam logic [7:0] IDX_NONE = 8'hFF;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  smb_line_sync u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  st_e               st_q;
  kind_e             kind_q;
  logic [3:0]        bit_cnt_q;
  logic [7:0]        rx_sr_q, tx_sr_q, idx_q;
  logic [6:0]        off_q;
  logic              oe_q, byte_mode_q, rd_dir_q, cnt_pend_q, mack_q;
  logic              we_q;
  logic [AW-1:0]     waddr_q;
  logic [7:0]        wdata_q;
  logic [N_REGS-1:0][7:0] regs;
  logic [7:0]        rd_byte, next_tx;
  logic [7:0]        idx_step;

  smb_reg_bank #(.N_REGS(N_REGS), .AW(AW), .RST_VAL(RST_VAL)) u_bank (
    .clk_i, .rst_ni, .we_i(we_q), .waddr_i(waddr_q), .wdata_i(wdata_q), .regs_o(regs)
  );

  assign regs_o   = regs;
  assign sda_oe_o = oe_q;
  assign rd_byte  = (idx_q < NREG8) ? regs[idx_q[AW-1:0]] : 8'h00;
  assign next_tx  = cnt_pend_q ? NREG8 : rd_byte;
  // byte mode parks the index out of range after one access
  assign idx_step = byte_mode_q ? IDX_NONE : ((idx_q == IDX_NONE) ? IDX_NONE : idx_q + 8'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; kind_q <= K_ADDR; bit_cnt_q <= '0;
      rx_sr_q <= '0; tx_sr_q <= '0; idx_q <= '0; off_q <= '0;
      oe_q <= 1'b0; byte_mode_q <= 1'b0; rd_dir_q <= 1'b0; cnt_pend_q <= 1'b0; mack_q <= 1'b0;
      we_q <= 1'b0; waddr_q <= '0; wdata_q <= '0;
    end else begin
      we_q <= 1'b0;
      if (stop_det) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else if (start_det) begin
        st_q <= ST_RX; kind_q <= K_ADDR; bit_cnt_q <= '0; oe_q <= 1'b0;
      end else if (st_q != ST_IDLE) begin
        if (scl_rise) begin
          bit_cnt_q <= bit_cnt_q + 4'd1;
          if (st_q == ST_RX && bit_cnt_q < 4'd8) rx_sr_q <= {rx_sr_q[6:0], sda_s};
          if (bit_cnt_q == 4'd8) mack_q <= ~sda_s;
        end else if (scl_fall) begin
          if (bit_cnt_q == 4'd8) begin
            if (st_q == ST_TX) oe_q <= 1'b0;
            else begin
              unique case (kind_q)
                K_ADDR: begin
                  if (rx_sr_q[7:1] == ADDR7) begin
                    oe_q <= 1'b1; rd_dir_q <= rx_sr_q[0]; kind_q <= K_CMD;
                    if (rx_sr_q[0]) begin
                      idx_q      <= byte_mode_q ? {1'b0, off_q} : 8'h00;
                      cnt_pend_q <= ~byte_mode_q;
                    end
                  end else st_q <= ST_IDLE;
                end
                K_CMD: begin
                  oe_q <= 1'b1; byte_mode_q <= rx_sr_q[7]; off_q <= rx_sr_q[6:0];
                  idx_q  <= rx_sr_q[7] ? {1'b0, rx_sr_q[6:0]} : 8'h00;
                  kind_q <= rx_sr_q[7] ? K_DATA : K_CNT;
                end
                K_CNT: begin
                  oe_q <= 1'b1; kind_q <= K_DATA;
                end
                K_DATA: begin
                  oe_q <= 1'b1;
                  if (idx_q < NREG8) begin
                    we_q <= 1'b1; waddr_q <= idx_q[AW-1:0]; wdata_q <= rx_sr_q;
                  end
                  idx_q <= idx_step;
                end
              endcase
            end
          end else if (bit_cnt_q == 4'd9) begin
            bit_cnt_q <= '0;
            if ((st_q == ST_RX && rd_dir_q) || (st_q == ST_TX && mack_q)) begin
              st_q <= ST_TX; tx_sr_q <= next_tx; oe_q <= ~next_tx[7]; cnt_pend_q <= 1'b0;
              if (!cnt_pend_q) idx_q <= idx_step;
            end else begin
              oe_q <= 1'b0;
              if (st_q == ST_TX) st_q <= ST_IDLE;
            end
          end else if (st_q == ST_TX && bit_cnt_q != 4'd0) begin
            oe_q    <= ~tx_sr_q[6];
            tx_sr_q <= {tx_sr_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  // R10
  oe_edge_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> $past(!scl_s || start_det || stop_det));
  // R9
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> st_q == ST_IDLE && !oe_q);
  // R9
  start_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det && !stop_det |=> st_q == ST_RX && kind_q == K_ADDR && bit_cnt_q == 4'd0);
  // R10
  bit_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q <= 4'd9);
  // R7
  we_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> $past(idx_q) < NREG8);
endmodule

// File: tb/smb_ctl_slave_bench.sv
module smb_ctl_slave_bench;
  localparam int         NR = 6;
  localparam logic [7:0] RV = 8'h5A;
  localparam int         H  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  logic [NR*8-1:0] regs;
  wire  bus_sda = m_sda & ~sda_oe;

  smb_ctl_slave #(.ADDR7(7'h69), .N_REGS(NR), .RST_VAL(RV)) u_smb_ctl_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  int checks = 0, errors = 0;
  logic [7:0] mdl [NR];
  logic cmp_en = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the bank against the model (R1, R3, R5, R7, R8)
  always @(negedge clk) begin
    if (cmp_en) begin
      for (int i = 0; i < NR; i++) begin
        checks++;
        if (regs[i*8 +: 8] !== mdl[i]) begin
          errors++;
          $display("FAIL R3/R5 bank reg%0d actual=%0h expected=%0h", i, regs[i*8 +: 8], mdl[i]);
        end
      end
    end
  end

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; hw(H);
    m_sda = 1'b0; hw(H);
    m_scl = 1'b0; hw(2);
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; hw(H);
    m_scl = 1'b1; hw(H);
    m_sda = 1'b0; hw(H);
    m_scl = 1'b0; hw(2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hw(H);
    m_scl = 1'b1; hw(H);
    m_sda = 1'b1; hw(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit wr, input int widx, output bit ack);
    bit quiet = 1'b1;
    cmp_en = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hw(H);
      m_scl = 1'b1; hw(H/2);
      if (sda_oe) quiet = 1'b0;
      hw(H/2);
      m_scl = 1'b0;
    end
    m_sda = 1'b1; hw(H);
    m_scl = 1'b1; hw(H/2);
    ack = !bus_sda;
    if (wr && ack) mdl[widx] = b;
    hw(H/2);
    m_scl = 1'b0;
    cmp_en = 1'b1;
    chk(quiet, "R10 slave quiet during master bits", {31'd0, !quiet}, 0);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(H);
      m_scl = 1'b1; hw(H/2);
      b[i] = bus_sda;
      hw(H/2);
      m_scl = 1'b0;
    end
    m_sda = !mack; hw(H);
    m_scl = 1'b1; hw(H);
    m_scl = 1'b0; hw(2);
    m_sda = 1'b1;
  endtask

  task automatic byte_write(input logic [6:0] off, input logic [7:0] d);
    bit a;
    bus_start();
    send_byte(8'hD2, 0, 0, a); chk(a, "R2 addr ack", a, 1);
    send_byte({1'b1, off}, 0, 0, a); chk(a, "R10 cmd ack", a, 1);
    send_byte(d, (int'(off) < NR), (int'(off) < NR) ? int'(off) : 0, a);
    chk(a, "R3/R7 data ack", a, 1);
    bus_stop();
  endtask

  task automatic byte_read(input logic [6:0] off, input logic [7:0] exp, input string tag);
    bit a; logic [7:0] d;
    bus_start();
    send_byte(8'hD2, 0, 0, a);
    send_byte({1'b1, off}, 0, 0, a);
    bus_rstart();
    send_byte(8'hD3, 0, 0, a); chk(a, "R4 read addr ack", a, 1);
    recv_byte(0, d);
    chk(d === exp, tag, d, exp);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit a; logic [7:0] d;
    for (int i = 0; i < NR; i++) mdl[i] = RV;
    hw(4); rst_n = 1'b1; hw(4);
    // R1
    chk(sda_oe === 1'b0, "R1 sda released after reset", sda_oe, 0);
    chk(regs === {NR{RV}}, "R1 reset bank", regs[7:0], RV);
    cmp_en = 1'b1;

    // R3 byte write, R4 byte read
    byte_write(7'd2, 8'h3C);
    byte_read(7'd2, 8'h3C, "R4 byte read reg2");
    chk(sda_oe === 1'b0, "R6 released after read NACK", sda_oe, 0);

    // R5 block write of 3 bytes then STOP
    bus_start();
    send_byte(8'hD2, 0, 0, a);
    send_byte(8'h00, 0, 0, a); chk(a, "R5 block cmd ack", a, 1);
    send_byte(8'h03, 0, 0, a); chk(a, "R5 count ack", a, 1);
    send_byte(8'h11, 1, 0, a);
    send_byte(8'h22, 1, 1, a);
    send_byte(8'hC3, 1, 2, a); chk(a, "R5 last block byte ack", a, 1);
    bus_stop();
    chk(regs[47:24] === {3{RV}}, "R5 upper regs untouched", regs[31:24], RV);

    // R6 block read past end (R7 zero fill)
    bus_start();
    send_byte(8'hD2, 0, 0, a);
    send_byte(8'h00, 0, 0, a);
    bus_rstart();
    send_byte(8'hD3, 0, 0, a); chk(a, "R6 block read addr ack", a, 1);
    recv_byte(1, d); chk(d === 8'(NR), "R6 count byte", d, NR);
    for (int i = 0; i < NR; i++) begin
      recv_byte(1, d); chk(d === mdl[i], "R6 block read data", d, mdl[i]);
    end
    recv_byte(0, d); chk(d === 8'h00, "R7 block read past end", d, 0);
    hw(4);
    chk(sda_oe === 1'b0, "R6 SDA released after NACK", sda_oe, 0);
    bus_stop();

    // R2 foreign address ignored
    bus_start();
    send_byte(8'hA4, 0, 0, a); chk(!a, "R2 foreign addr NACK", a, 0);
    send_byte(8'h81, 0, 0, a); chk(!a, "R2 silent after foreign addr", a, 0);
    send_byte(8'h77, 0, 0, a);
    bus_stop();
    chk(regs[15:8] === mdl[1], "R2 reg1 unchanged", regs[15:8], mdl[1]);

    // R7 out of range
    byte_write(7'h70, 8'h99);
    byte_write(7'd6, 8'h98);
    byte_read(7'd6, 8'h00, "R7 read beyond bank");

    // R8 extra bytes in byte mode discarded
    bus_start();
    send_byte(8'hD2, 0, 0, a);
    send_byte(8'h84, 0, 0, a);
    send_byte(8'h44, 1, 4, a);
    send_byte(8'h55, 0, 0, a); chk(a, "R8 extra byte ACKed", a, 1);
    send_byte(8'h66, 0, 0, a);
    bus_stop();
    chk(regs[39:32] === 8'h44, "R8 reg4 holds first byte", regs[39:32], 8'h44);

    // R9 repeated START restarts address decoding in a write
    bus_start();
    send_byte(8'hD2, 0, 0, a);
    send_byte(8'h85, 0, 0, a);
    bus_rstart();
    send_byte(8'hD2, 0, 0, a); chk(a, "R9 addr after rstart ack", a, 1);
    send_byte(8'h81, 0, 0, a);
    send_byte(8'hE7, 1, 1, a);
    bus_stop();
    chk(regs[15:8] === 8'hE7 && regs[47:40] === RV, "R9 write after rstart", regs[15:8], 8'hE7);
    byte_read(7'd1, 8'hE7, "R4 byte read reg1");

    hw(10);
    cmp_en = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule